// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator with Serial Retune and Field Reset

This block keeps the running phase of the colour subcarrier for a composite video encoder. A 32-bit accumulator adds a step value on every pixel clock. The downstream sine lookup, modulator and burst gate use the accumulator output as the subcarrier angle.

One control pin, `ctl_pin`, has three possible uses, chosen by `pin_mode`. As a phase-reset request, a rising edge asks for the accumulator to be reloaded with its field-zero value. The reload happens at the next field start. As a serial retune input, an external video decoder sends frames, two pixel clocks per bit, that carry a new frequency word. That word replaces the step at the next line start, so the subcarrier follows line-length variation one line at a time. In the remaining modes the pin is ignored.

In every mode except serial retune, the step is the programmed frequency word `prog_freq`. In serial retune mode `prog_freq` is not used and should be written as zero.

Top module: `subcarrier_phase_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `phase` becomes 0 and `field0` becomes 0. After reset the serial step is 0.
- R2: Modes are encoded on `pin_mode` as 2'b01 = phase reset, 2'b10 = serial retune, 2'b00 and 2'b11 = pin unused. In every mode other than 2'b10, `phase` grows by `prog_freq` (modulo 2^32) on each clock edge.
- R3: In mode 2'b01, a rising edge on `ctl_pin` leaves `phase` counting normally. At the first later edge where `field_start` is high, `phase` is loaded with `FIELD0_PHASE` (default 0) in place of the addition. `field0` is high for the one cycle that follows that edge.
- R4: Any number of rising edges within one field cause a single reload. A `field_start` with no rising edge since the previous reload does no reload. A rising edge sampled at the same edge as `field_start` counts toward the following field only.
- R5: In mode 2'b10, a serial frame starts with a rising edge that follows at least `IDLE_MIN` (default 4) low clocks. That start bit takes two clocks. Then come 67 data bits of two clocks each, each sampled on its second clock, bit 0 first. Bits 0 to 21 form the 22-bit frequency value (bit 0 is the LSB). Bits 22 to 66 are ignored.
- R6: A received value does not change `phase` before the next `line_start`. At that edge the step becomes the value shifted left by 10 bits (the value sits in the top 22 bits of the 32-bit step). The addition at that same edge still uses the old step.
- R7: In mode 2'b10, `prog_freq` has no effect on `phase`.
- R8: In modes 2'b00 and 2'b11, edges on `ctl_pin` and `field_start` never reload `phase`, and `field0` stays 0.
- R9: In mode 2'b10, a rising edge that comes after fewer than `IDLE_MIN` low clocks starts no frame. Bits that follow it do not update the received value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_pin | input | 1 | Shared phase-reset / serial retune pin |
| pin_mode | input | 2 | Function of `ctl_pin` (see R2) |
| prog_freq | input | 32 | Programmed accumulator step |
| line_start | input | 1 | One-clock strobe at the start of each line |
| field_start | input | 1 | One-clock strobe at the start of each field |
| phase | output | 32 | Current subcarrier phase |
| field0 | output | 1 | High for one cycle after a field-zero reload |

## Verification
Two events can meet at one clock edge: a rising edge on the reset pin and the field-start strobe. The bench sets up that case with no request pending, driving the pin high in the same cycle as `field_start`. It then expects no reload at that boundary and exactly one reload at the next `field_start`. A second overlap is between serial retune and the line strobe. Here the bench sends a frame followed by a second, too-closely-spaced start, and checks that the first value, and only the first, is applied at the later line start.

// File: rtl/scpu_pkg.sv
// Shared definitions for the subcarrier phase unit.
// Assumes: the two-bit mode code is supplied by a register outside the block.
package scpu_pkg;

    // Function selected for the shared control pin
    typedef enum logic [1:0] {
        SCM_IDLE0       = 2'b00,
        SCM_PHASE_RESET = 2'b01,
        SCM_RETUNE      = 2'b10,
        SCM_IDLE3       = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/scpu_rtc_rx.sv
// Serial retune receiver.
// Detects a frame start (rising edge after IDLE_MIN low clocks). It then
// samples FRAME_BITS data bits, each two clocks long, on the second clock
// of each bit, LSB first. The first FREQ_BITS bits are kept; the rest are
// dropped. A one-cycle done pulse follows the last sample.
// Assumes: pin is synchronous to clk; enable low holds the receiver idle.
module scpu_rtc_rx #(
    parameter int unsigned FRAME_BITS = 67,
    parameter int unsigned FREQ_BITS  = 22,
    parameter int unsigned IDLE_MIN   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 pin,
    output logic [FREQ_BITS-1:0] word_o,
    output logic                 done_o
);
    localparam int unsigned LAST_CYC = 2 * FRAME_BITS + 1;
    localparam int unsigned CW       = $clog2(LAST_CYC + 1);
    localparam int unsigned LW       = $clog2(IDLE_MIN + 1);

    logic                 busy_q;
    logic [CW-1:0]        cyc_q;
    logic [LW-1:0]        low_q;
    logic [FREQ_BITS-1:0] sr_q;
    logic                 done_q;
    logic [CW-1:0]        bit_idx;
    logic                 sample_now;

    // Index of the data bit whose second clock is the current cycle
    always_comb begin
        bit_idx    = (cyc_q - CW'(3)) >> 1;
        sample_now = busy_q && (cyc_q >= CW'(3)) && cyc_q[0];
    end

    // Idle-low counting, start detection, bit sampling and frame end
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
            low_q  <= '0;
            sr_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (pin) begin
                    low_q <= '0;
                    if (low_q >= LW'(IDLE_MIN)) begin
                        busy_q <= 1'b1;
                        cyc_q  <= CW'(1);
                    end
                end else if (low_q < LW'(IDLE_MIN)) begin
                    low_q <= low_q + LW'(1);
                end
            end else begin
                cyc_q <= cyc_q + CW'(1);
                if (sample_now && (bit_idx < CW'(FREQ_BITS))) begin
                    sr_q <= {pin, sr_q[FREQ_BITS-1:1]};
                end
                if (cyc_q == CW'(LAST_CYC)) begin
                    busy_q <= 1'b0;
                    cyc_q  <= '0;
                    low_q  <= '0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign word_o = sr_q;
    assign done_o = done_q;

    AST_RX_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        busy_q |-> (cyc_q != '0) && (cyc_q <= CW'(LAST_CYC))); // R5
    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        done_q |=> !done_q); // R5
    AST_RX_SHORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        (!busy_q && pin && (low_q < LW'(IDLE_MIN))) |=> !busy_q); // R9
endmodule

// File: rtl/scpu_reset_ctl.sv
// Field-aligned phase reset requester.
// A rising edge on the pin while armed sets one pending request. The
// request is used, and cleared, at the next field start. An edge that
// coincides with the field start stays pending for the following field.
// Assumes: pin is synchronous to clk; disarming drops any pending request.
module scpu_reset_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pin,
    input  logic field_start,
    output logic load_o
);
    logic pin_q;
    logic pend_q;
    logic rise;

    // Rising-edge detect on the shared pin
    assign rise = pin && !pin_q;

    // Reload fires only when a request was already waiting at the boundary
    assign load_o = arm && field_start && pend_q;

    // Pin history and single-entry pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pin_q <= pin;
            if (!arm) begin
                pend_q <= 1'b0;
            end else if (rise) begin
                pend_q <= 1'b1;
            end else if (field_start) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_RST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && rise) |=> pend_q); // R3
    AST_RST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !rise) |=> !pend_q); // R4
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && arm && !field_start) |=> pend_q); // R4
endmodule

// File: rtl/scpu_phase_acc.sv
// Step selection and phase accumulator.
// Keeps a shadow of the last received serial word. In retune mode the
// shadow is moved into the step at the next line start. The accumulator
// adds the step every clock, or loads FIELD0_PHASE on a field reload.
// Assumes: rx_done and line_start are one-clock strobes.
module scpu_phase_acc #(
    parameter int unsigned ACC_W              = 32,
    parameter int unsigned FREQ_BITS          = 22,
    parameter logic [ACC_W-1:0] FIELD0_PHASE  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rtc_sel,
    input  logic [ACC_W-1:0]     prog_step,
    input  logic [FREQ_BITS-1:0] rx_word,
    input  logic                 rx_done,
    input  logic                 line_start,
    input  logic                 load_f0,
    output logic [ACC_W-1:0]     phase_o,
    output logic                 f0_o
);
    localparam int unsigned PAD = ACC_W - FREQ_BITS;

    logic [FREQ_BITS-1:0] shadow_q;
    logic                 shv_q;
    logic [ACC_W-1:0]     rtc_step_q;
    logic [ACC_W-1:0]     shadow_wide;
    logic [ACC_W-1:0]     step;
    logic [ACC_W-1:0]     phase_q;
    logic                 f0_q;

    // Left-align the received word inside the accumulator step
    generate
        if (PAD > 0) begin : g_pad
            assign shadow_wide = {shadow_q, {PAD{1'b0}}};
        end else begin : g_nopad
            assign shadow_wide = shadow_q;
        end
    endgenerate

    // Step source: serial step in retune mode, programmed word otherwise
    assign step = rtc_sel ? rtc_step_q : prog_step;

    // Shadow capture and line-aligned step update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q   <= '0;
            shv_q      <= 1'b0;
            rtc_step_q <= '0;
        end else if (!rtc_sel) begin
            shv_q <= 1'b0;
        end else begin
            if (line_start && shv_q) begin
                rtc_step_q <= shadow_wide;
            end
            if (rx_done) begin
                shadow_q <= rx_word;
                shv_q    <= 1'b1;
            end else if (line_start) begin
                shv_q <= 1'b0;
            end
        end
    end

    // Accumulate or reload, and flag the reload for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            f0_q    <= 1'b0;
        end else begin
            phase_q <= load_f0 ? FIELD0_PHASE : phase_q + step;
            f0_q    <= load_f0;
        end
    end

    assign phase_o = phase_q;
    assign f0_o    = f0_q;

    AST_F0_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        f0_q |-> (phase_q == FIELD0_PHASE)); // R3
    AST_STEP_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(rtc_step_q)); // R6
endmodule

// File: rtl/subcarrier_phase_unit.sv
// Subcarrier phase unit top level.
// Decodes the pin mode and sends the shared pin to either the field
// reset requester or the serial retune receiver. Both feed the phase
// accumulator.
// Assumes: all inputs are synchronous to clk.
module subcarrier_phase_unit #(
    parameter int unsigned ACC_W             = 32,
    parameter int unsigned FREQ_BITS         = 22,
    parameter int unsigned FRAME_BITS        = 67,
    parameter int unsigned IDLE_MIN          = 4,
    parameter logic [ACC_W-1:0] FIELD0_PHASE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_pin,
    input  logic [1:0]       pin_mode,
    input  logic [ACC_W-1:0] prog_freq,
    input  logic             line_start,
    input  logic             field_start,
    output logic [ACC_W-1:0] phase,
    output logic             field0
);
    import scpu_pkg::*;

    pin_mode_e            mode;
    logic                 arm_reset;
    logic                 rtc_on;
    logic                 load_f0;
    logic [FREQ_BITS-1:0] rx_word;
    logic                 rx_done;

    // Mode decode for the shared pin
    always_comb begin
        mode      = pin_mode_e'(pin_mode);
        arm_reset = (mode == SCM_PHASE_RESET);
        rtc_on    = (mode == SCM_RETUNE);
    end

    scpu_reset_ctl u_reset (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm_reset),
        .pin         (ctl_pin),
        .field_start (field_start),
        .load_o      (load_f0)
    );

    scpu_rtc_rx #(
        .FRAME_BITS (FRAME_BITS),
        .FREQ_BITS  (FREQ_BITS),
        .IDLE_MIN   (IDLE_MIN)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rtc_on),
        .pin    (ctl_pin),
        .word_o (rx_word),
        .done_o (rx_done)
    );

    scpu_phase_acc #(
        .ACC_W        (ACC_W),
        .FREQ_BITS    (FREQ_BITS),
        .FIELD0_PHASE (FIELD0_PHASE)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rtc_sel    (rtc_on),
        .prog_step  (prog_freq),
        .rx_word    (rx_word),
        .rx_done    (rx_done),
        .line_start (line_start),
        .load_f0    (load_f0),
        .phase_o    (phase),
        .f0_o       (field0)
    );

    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_reset) |=> !field0); // R8
endmodule

// File: tb/subcarrier_phase_unit_tb.sv
// Bench for subcarrier_phase_unit: a vector table for plain accumulation,
// then directed tests for reset, field reload and serial retune.
module subcarrier_phase_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_pin = 1'b0;
    logic [1:0]  pin_mode = 2'b00;
    logic [31:0] prog_freq = '0;
    logic        line_start = 1'b0;
    logic        field_start = 1'b0;
    logic [31:0] phase;
    logic        field0;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    subcarrier_phase_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_pin(ctl_pin), .pin_mode(pin_mode),
        .prog_freq(prog_freq), .line_start(line_start),
        .field_start(field_start), .phase(phase), .field0(field0)
    );

    typedef struct packed {
        logic [31:0] freq;
        logic [7:0]  n;
        logic [31:0] delta;
    } vec_t;

    localparam vec_t VECS [0:3] = '{
        '{32'h0000_0100, 8'd10, 32'h0000_0A00},
        '{32'h1000_0000, 8'd17, 32'h1000_0000},
        '{32'h0000_0000, 8'd5,  32'h0000_0000},
        '{32'hFFFF_FFFF, 8'd3,  32'hFFFF_FFFD}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input logic [21:0] val);
        ctl_pin = 1'b1;
        tick(2);
        for (int k = 0; k < 67; k++) begin
            ctl_pin = (k < 22) ? val[k] : 1'b1;
            tick(2);
        end
        ctl_pin = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] p;
        logic [31:0] step_v;
        // R1: reset state, with a nonzero word offered
        prog_freq = 32'h100;
        tick(3);
        chk("R1 phase", phase, 32'h0);
        chk("R1 field0", {31'h0, field0}, 32'h0);
        rst_n = 1'b1;

        // R2: table-driven accumulation in an unused-pin mode
        for (int v = 0; v < 4; v++) begin
            prog_freq = VECS[v].freq;
            p = phase;
            tick(int'(VECS[v].n));
            chk("R2 delta", phase - p, VECS[v].delta);
        end

        // R3: deferred reload in phase-reset mode
        pin_mode  = 2'b01;
        prog_freq = 32'h100;
        tick(3);
        p = phase;
        ctl_pin = 1'b1; tick(1);
        ctl_pin = 1'b0; tick(1);
        chk("R3 no immediate reset", phase, p + 32'h200);
        field_start = 1'b1; tick(1);
        field_start = 1'b0;
        chk("R3 reload", phase, 32'h0);
        chk("R3 flag high", {31'h0, field0}, 32'h1);
        tick(1);
        chk("R3 flag low", {31'h0, field0}, 32'h0);
        chk("R3 counting resumes", phase, 32'h100);

        // R4: several edges, one reload
        ctl_pin = 1'b1; tick(1); ctl_pin = 1'b0; tick(1);
        ctl_pin = 1'b1; tick(1); ctl_pin = 1'b0; tick(3);
        field_start = 1'b1; tick(1); field_start = 1'b0;
        chk("R4 single reload", phase, 32'h0);
        tick(3);
        p = phase;
        field_start = 1'b1; tick(1); field_start = 1'b0;
        chk("R4 no second reload", phase, p + 32'h100);
        chk("R4 no flag", {31'h0, field0}, 32'h0);
        // R4: edge coinciding with field start belongs to next field
        tick(2);
        p = phase;
        ctl_pin = 1'b1; field_start = 1'b1; tick(1);
        ctl_pin = 1'b0; field_start = 1'b0;
        chk("R4 coincident edge deferred", phase, p + 32'h100);
        tick(2);
        field_start = 1'b1; tick(1); field_start = 1'b0;
        chk("R4 coincident edge applied", phase, 32'h0);
        chk("R4 coincident flag", {31'h0, field0}, 32'h1);

        // R8: unused mode ignores pin and field start
        pin_mode = 2'b11;
        tick(1);
        p = phase;
        ctl_pin = 1'b1; tick(1); ctl_pin = 1'b0; tick(1);
        field_start = 1'b1; tick(1); field_start = 1'b0;
        chk("R8 no reload", phase, p + 32'h300);
        chk("R8 no flag", {31'h0, field0}, 32'h0);

        // R7: serial mode ignores programmed word; step starts at 0
        pin_mode  = 2'b10;
        prog_freq = 32'hDEAD_BEEF;
        tick(8);
        p = phase;
        tick(5);
        chk("R7 prog word ignored", phase, p);

        // R5/R9: valid frame, then a start after too short an idle
        send_frame(22'h2A5C3);
        tick(2);
        send_frame(22'h155555);
        tick(6);
        chk("R6 not before line start", phase, p);
        line_start = 1'b1; tick(1); line_start = 1'b0;
        chk("R6 old step at line edge", phase, p);
        p = phase;
        tick(4);
        step_v = {22'h2A5C3, 10'b0};
        chk("R5 R9 received step applied", phase - p, step_v * 32'd4);

        // R6: another line start without a new frame keeps the step
        line_start = 1'b1; tick(1); line_start = 1'b0;
        p = phase;
        tick(2);
        chk("R6 step held", phase - p, step_v * 32'd2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule